// File: doc/BRIEF.md
# Zero-Cross Flag Status Register

This block reports mains zero-cross events to a processor. An external zero-cross pulse arrives with no fixed relation to the clock, so it passes through a synchronizer first. Each rising edge of the synchronized signal then latches a sticky flag. The processor reads one byte. The top bit of that byte is the flag, and the seven bits below it come from a small scratch field that the processor writes.

The read has side effects. The flag clears once the byte has been returned. If the flag was set at the time of the read, a companion interrupt counter is also reset to zero. That counter advances on every periodic interrupt tick and stops at its maximum value. Software therefore reads the register once per interrupt. A set flag tells it that a zero crossing happened, and the counter restarts from that point. Reads made while the flag is clear leave the counter alone.

Top module: `zcf_status_reg`

## Requirements
- R1: `rd_data` always presents the flag in bit 7 and the stored field in bits 6:0. The value present during a cycle with `rd_en` high is the value the read returns.
- R2: A clock edge with `rd_en` high clears the flag, unless a new rise arrives in that same cycle.
- R3: A read taken while the flag is set leaves `irq_count` at 0 after that edge. This holds even if `irq_tick` is high in the same cycle.
- R4: A read taken while the flag is clear leaves `irq_count` unchanged when no tick is present.
- R5: A 0-to-1 transition of `zc_in` sets the flag. With two synchronizer stages, the flag is visible on `rd_data[7]` after the third rising clock edge that samples the high level. Holding `zc_in` high afterwards sets the flag no further.
- R6: When a rise and a read-clear meet in the same cycle, the flag ends set.
- R7: A clock edge with `wr_en` high stores `wr_data[6:0]` into bits 6:0. `wr_data[7]` is ignored, and writes never change the flag.
- R8: Each edge with `irq_tick` high, and no counter-clearing read, adds one to `irq_count`. The count saturates at 255 (all ones for the default 8-bit width).
- R9: An active-low `rst_n` clears the flag, the stored field, the counter and the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_in | input | 1 | Asynchronous zero-cross indication |
| irq_tick | input | 1 | Periodic interrupt tick, one cycle per tick |
| wr_en | input | 1 | Write strobe for the stored field |
| wr_data | input | 8 | Write data; bits 6:0 are stored |
| rd_en | input | 1 | Read strobe carrying the clear side effects |
| rd_data | output | 8 | Flag in bit 7, stored field in bits 6:0 |
| irq_count | output | 8 | Saturating interrupt counter |

## Verification
The assertions check the following rules on every cycle:
- the flag falls after a read and rises after an edge pulse;
- the flag holds when neither event occurs;
- a read of a set flag zeroes the counter;
- a read of a clear flag leaves the counter untouched;
- the counter increments and saturates correctly;
- written bits land in the field.

Only the bench scenarios can show the end-to-end input latency, since the assertions start from the internal edge pulse. The bench scenarios also show that a held-high input sets the flag only once. Finally, they show the exact cycle in which the set-wins collision happens at the pins.

// File: rtl/zcf_pkg.sv
package zcf_pkg;
    // Side effects decoded from one cycle of strobes
    typedef struct packed {
        logic set_flag;
        logic clr_flag;
        logic cnt_clr;
        logic cnt_inc;
    } zcf_evt_t;
endpackage

// File: rtl/zcf_sync.sv
module zcf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = async_in;
        for (int i = 1; i < CHAIN_W; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // last synchronized stage high, history stage low
    assign rise_o = s_q.chain[STAGES-1] & ~s_q.chain[STAGES];
endmodule

// File: rtl/zcf_sat_counter.sv
module zcf_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] value;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr)                         c_d.value = '0;
        else if (inc && c_q.value != CNT_MAX) c_d.value = c_q.value + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt = c_q.value;
endmodule

// File: rtl/zcf_status_reg.sv
module zcf_status_reg #(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zc_in,
    input  logic              irq_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  irq_count
);
    import zcf_pkg::*;

    localparam int STORE_W = DATA_W - 1;

    typedef struct packed {
        logic               flag;
        logic [STORE_W-1:0] store;
    } reg_t;

    reg_t     r_d, r_q;
    zcf_evt_t evt;
    logic     zc_rise;
    logic     unused_wr_msb;

    assign unused_wr_msb = wr_data[DATA_W-1];

    zcf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (zc_in),
        .rise_o   (zc_rise)
    );

    always_comb begin
        evt.set_flag = zc_rise;
        evt.clr_flag = rd_en;
        evt.cnt_clr  = rd_en & r_q.flag;
        evt.cnt_inc  = irq_tick;

        r_d = r_q;
        if (evt.set_flag)      r_d.flag = 1'b1;
        else if (evt.clr_flag) r_d.flag = 1'b0;
        if (wr_en)             r_d.store = wr_data[STORE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    zcf_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (evt.cnt_inc),
        .clr   (evt.cnt_clr),
        .cnt   (irq_count)
    );

    assign rd_data = {r_q.flag, r_q.store};
endmodule

// File: rtl/zcf_status_reg_chk.sv
module zcf_status_reg_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_tick,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  irq_count,
    input logic              zc_rise
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !zc_rise |=> !rd_data[DATA_W-1]);

    a_r3_cnt_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_data[DATA_W-1] |=> irq_count == '0);

    a_r4_cnt_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_data[DATA_W-1] && !irq_tick |=> $stable(irq_count));

    a_r5_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        zc_rise |=> rd_data[DATA_W-1]);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        zc_rise && rd_en |=> rd_data[DATA_W-1]);

    a_r7_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en && !zc_rise |=> $stable(rd_data[DATA_W-1]));

    a_r7_field_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[DATA_W-2:0] == $past(wr_data[DATA_W-2:0]));

    a_r8_increment: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tick && !(rd_en && rd_data[DATA_W-1]) && irq_count != CNT_MAX
        |=> irq_count == $past(irq_count) + 1'b1);

    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tick && !(rd_en && rd_data[DATA_W-1]) && irq_count == CNT_MAX
        |=> irq_count == CNT_MAX);
endmodule

bind zcf_status_reg zcf_status_reg_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_tick  (irq_tick),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .irq_count (irq_count),
    .zc_rise   (zc_rise)
);

// File: tb/zcf_status_reg_bench.sv
module zcf_status_reg_bench;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       zc_in = 1'b0;
    logic       irq_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] irq_count;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zcf_status_reg u_zcf_status_reg (
        .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .irq_tick(irq_tick),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .irq_count(irq_count)
    );

    task automatic check(input string what, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, actual, expected);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; zc_in = 0; irq_tick = 0; wr_en = 0; rd_en = 0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Raise zc_in, wait three edges (flag now set), drop it, let chain settle
    task automatic zc_pulse();
        zc_in = 1'b1;
        repeat (3) @(negedge clk);
        zc_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_read(output logic [7:0] val);
        rd_en = 1'b1;
        val = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        irq_tick = 1'b1;
        repeat (n) @(negedge clk);
        irq_tick = 1'b0;
    endtask

    task automatic t_reset_state();
        // R9: dirty everything, then reset
        do_write(8'h7F);
        ticks(5);
        zc_pulse();
        do_reset();
        check("R9 rd_data after reset", rd_data, 8'h00);
        check("R9 irq_count after reset", irq_count, 0);
    endtask

    task automatic t_rise_latency();
        logic [7:0] v;
        zc_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 flag not yet set after two edges", rd_data[7], 0);
        @(negedge clk);
        check("R5 flag set after third edge", rd_data[7], 1);
        // held high: read clears and nothing re-sets it
        do_read(v);
        check("R1 read returns flag in bit 7", v, 8'h80);
        repeat (5) @(negedge clk);
        check("R5 held level sets flag once", rd_data[7], 0);
        zc_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_write_field();
        do_write(8'hD5);
        check("R7 bit 7 of write ignored", rd_data, 8'h55);
        zc_pulse();
        do_write(8'h2A);
        check("R7 write keeps flag, R1 field in 6:0", rd_data, 8'hAA);
        do_write(8'h00);
        check("R7 write of zero keeps flag", rd_data, 8'h80);
        begin
            logic [7:0] v;
            do_read(v);
        end
        check("R2 flag clear after read", rd_data, 8'h00);
    endtask

    task automatic t_saturation();
        do_reset();
        ticks(254);
        check("R8 count at 254", irq_count, 254);
        ticks(1);
        check("R8 count at 255", irq_count, 255);
        ticks(6);
        check("R8 count saturates at 255", irq_count, 255);
    endtask

    task automatic t_read_effects();
        logic [7:0] v;
        // count is 255 from t_saturation, flag clear
        do_read(v);
        check("R4 clear-flag read returns 0", v, 8'h00);
        check("R4 clear-flag read keeps count", irq_count, 255);
        zc_pulse();
        check("R4 count untouched by rise", irq_count, 255);
        do_read(v);
        check("R3 set-flag read returns 0x80", v, 8'h80);
        check("R3 set-flag read zeroes count", irq_count, 0);
        check("R2 flag cleared by read", rd_data[7], 0);
        ticks(7);
        check("R8 count after 7 ticks", irq_count, 7);
        // read with set flag and tick in the same cycle
        zc_pulse();
        irq_tick = 1'b1;
        do_read(v);
        irq_tick = 1'b0;
        check("R3 clear wins over tick", irq_count, 0);
        ticks(3);
        do_read(v);
        check("R4 clear-flag read with count 3", irq_count, 3);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        zc_pulse();
        ticks(4);
        zc_in = 1'b1;
        repeat (2) @(negedge clk);
        // rise pulse is active during this cycle
        do_read(v);
        check("R6 read value before collision", v, 8'h80);
        check("R6 flag stays set on collision", rd_data[7], 1);
        check("R3 counter zeroed on collision read", irq_count, 0);
        zc_in = 1'b0;
        repeat (3) @(negedge clk);
        do_read(v);
        check("R2 later read clears flag", rd_data[7], 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        check("R9 initial rd_data", rd_data, 8'h00);
        check("R9 initial irq_count", irq_count, 0);
        t_rise_latency();
        t_write_field();
        t_reset_state();
        t_saturation();
        t_read_effects();
        t_set_wins();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule